// File: doc/BRIEF.md
# Power-On Strap Sampling Controller

This block runs the configuration phase of a clock generator's dual-purpose pins. While power-good is low, and for a fixed window of reference-clock cycles after it rises, every dual-purpose pin stays in high impedance. This lets the external pull resistors set each pin's level. On the last cycle of the window, the pin levels, taken through a two-flop synchronizer, are latched as configuration straps. The output drivers of all pins are then enabled together, and the pins carry clocks from that point on.

Four of the straps form a 4-bit frequency code. The fifth strap, the mode strap, decides what a separate shared pin does. With the mode strap at 1 the shared pin drives a reference clock. With it at 0 the shared pin is an active-low stop input. A register bit chooses whether the effective frequency code comes from the straps or from a register-supplied code.

The straps are held across every reset except a drop of power-good. A drop of power-good models a full power cycle and restarts the window.

Top module: `strap_ctrl`

## Requirements
- R1: `pin_oe` is all zeros while `pwr_good` is low and through the sampling window. It becomes all ones at the (WIN_CYC+2)-th rising clock edge after `pwr_good` rises, and is never partly set.
- R2: `strap_q` takes the `pin_in` levels sampled at the WIN_CYC-th rising edge after `pwr_good` rises, which is two edges before the drivers turn on. Pin changes after that edge are ignored until the next power cycle.
- R3: Before the straps are latched, `strap_q` holds its default 5'b10111. The bit map is [0]=FS0, [1]=FS1, [2]=FS2, [3]=FS3, [4]=mode. This gives FS3 a default of 0 and every other strap a default of 1.
- R4: Asserting `rst_n` low clears neither `strap_q` nor `pin_oe`, and it does not restart the window.
- R5: `pwr_good` going low clears `strap_q` to its default and `pin_oe` to zero at once, without waiting for a clock edge. When `pwr_good` returns, a new window starts and new straps are latched.
- R6: `freq_code` is a register loaded on each clock edge. It loads `sw_code` when `sw_sel` is 1 and `strap_q[3:0]` when `sw_sel` is 0, so a change shows one edge later. While the synchronized `rst_n` is low, `freq_code` holds 4'b0111.
- R7: After the window with the mode strap at 0, `shr_oe` is 0 and `stop_req` equals the inverse of `shr_stop_n`. Before the straps are latched, both `shr_oe` and `stop_req` are 0.
- R8: After the window with the mode strap at 1, `shr_oe` is 1 and `shr_stop_n` has no effect: `stop_req` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| pwr_good | input | 1 | Supply above threshold; low acts as the power-cycle reset |
| rst_n | input | 1 | Asynchronous active-low system reset; does not touch the straps |
| pin_in | input | 5 | Levels read from the dual-purpose pins |
| sw_sel | input | 1 | Register bit: 1 selects `sw_code` as the frequency code |
| sw_code | input | 4 | Register-supplied frequency code |
| shr_stop_n | input | 1 | Level on the shared pin when it serves as the stop input |
| pin_oe | output | 5 | Output enables for the dual-purpose pins |
| strap_q | output | 5 | Latched straps, {mode, FS3, FS2, FS1, FS0} |
| freq_code | output | 4 | Effective frequency code |
| shr_oe | output | 1 | Drive enable for the reference clock on the shared pin |
| stop_req | output | 1 | Stop request decoded from the shared pin |

## Verification
Power-good passes through a two-flop reset synchronizer, and the window counter needs WIN_CYC edges after that. The drivers therefore turn on at edge WIN_CYC+2, and the latched value is the pin level seen at edge WIN_CYC. The bench counts those edges exactly. It checks at the falling edge just before and just after the release, and it changes the pins one edge before and one edge after the capture point. `freq_code` is checked on the falling edge after the one rising edge that loads it. `stop_req`, `shr_oe`, and the effect of a power-good drop are combinational or asynchronous, so they are checked a short delay after the input changes, with no clock edge in between.

// File: rtl/strap_pkg.sv
package strap_pkg;
  localparam int          NPIN       = 5;
  localparam int          FS_W       = 4;
  localparam int          IDX_MODE   = 4;
  localparam logic [4:0]  STRAP_DFLT = 5'b10111;
  localparam logic [3:0]  CODE_DFLT  = STRAP_DFLT[FS_W-1:0];
endpackage

// File: rtl/strap_rst_sync.sv
module strap_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= stage_d;
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/strap_win_timer.sv
module strap_win_timer #(
  parameter int WIN_CYC = 28636
) (
  input  logic clk,
  input  logic por_n,
  output logic last_o,
  output logic done_o
);
  localparam int               CNT_W = (WIN_CYC > 2) ? $clog2(WIN_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(WIN_CYC - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;
  logic             at_last;

  assign at_last = !done_q && (cnt_q == LAST);

  always_comb begin
    cnt_d  = cnt_q;
    done_d = done_q;
    if (!done_q) begin
      if (at_last) done_d = 1'b1;
      else         cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign last_o = at_last;
  assign done_o = done_q;
endmodule

// File: rtl/strap_capture.sv
module strap_capture #(
  parameter int             NP   = 5,
  parameter logic [NP-1:0]  DFLT = '1
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic [NP-1:0] pin_i,
  input  logic          take_i,
  output logic [NP-1:0] strap_o
);
  for (genvar i = 0; i < NP; i++) begin : g_bit
    logic meta_q, sync_q, hold_q;
    logic hold_d;

    always_comb begin
      hold_d = hold_q;
      if (take_i) hold_d = sync_q;
    end

    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
        hold_q <= DFLT[i];
      end else begin
        meta_q <= pin_i[i];
        sync_q <= meta_q;
        hold_q <= hold_d;
      end
    end

    assign strap_o[i] = hold_q;
  end
endmodule

// File: rtl/strap_ctrl.sv
module strap_ctrl
  import strap_pkg::*;
#(
  parameter int WIN_CYC = 28636
) (
  input  logic            clk,
  input  logic            pwr_good,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pin_in,
  input  logic            sw_sel,
  input  logic [FS_W-1:0] sw_code,
  input  logic            shr_stop_n,
  output logic [NPIN-1:0] pin_oe,
  output logic [NPIN-1:0] strap_q,
  output logic [FS_W-1:0] freq_code,
  output logic            shr_oe,
  output logic            stop_req
);
  logic por_n, srst_n;
  logic win_last, win_done;
  logic [FS_W-1:0] code_q, code_d;

  strap_rst_sync u_por_sync (.clk(clk), .arst_n(pwr_good), .srst_n(por_n));
  strap_rst_sync u_sys_sync (.clk(clk), .arst_n(rst_n),    .srst_n(srst_n));

  strap_win_timer #(.WIN_CYC(WIN_CYC)) u_timer (
    .clk(clk), .por_n(por_n), .last_o(win_last), .done_o(win_done)
  );

  strap_capture #(.NP(NPIN), .DFLT(STRAP_DFLT)) u_cap (
    .clk(clk), .por_n(por_n), .pin_i(pin_in), .take_i(win_last), .strap_o(strap_q)
  );

  always_comb begin
    code_d = sw_sel ? sw_code : strap_q[FS_W-1:0];
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) code_q <= CODE_DFLT;
    else         code_q <= code_d;
  end

  assign freq_code = code_q;
  assign pin_oe    = {NPIN{win_done}};
  assign shr_oe    = win_done &  strap_q[IDX_MODE];
  assign stop_req  = win_done & ~strap_q[IDX_MODE] & ~shr_stop_n;
endmodule

// File: rtl/strap_ctrl_chk.sv
module strap_ctrl_chk
  import strap_pkg::*;
#(
  parameter int WIN_CYC = 28636
) (
  input logic            clk,
  input logic            pwr_good,
  input logic            rst_n,
  input logic            sw_sel,
  input logic [FS_W-1:0] sw_code,
  input logic [NPIN-1:0] pin_oe,
  input logic [NPIN-1:0] strap_q,
  input logic [FS_W-1:0] freq_code,
  input logic            shr_oe,
  input logic            stop_req
);
  int unsigned up_cnt;

  always_ff @(posedge clk or negedge pwr_good) begin
    if (!pwr_good)                    up_cnt <= 0;
    else if (up_cnt < WIN_CYC + 8)    up_cnt <= up_cnt + 1;
  end

  // R1: drivers stay off until the window has elapsed
  p_oe_late_r1: assert property (@(posedge clk) disable iff (!pwr_good)
    (pin_oe != '0) |-> (up_cnt >= WIN_CYC));

  // R1: enables switch as one group
  p_oe_group_r1: assert property (@(posedge clk) disable iff (!pwr_good)
    (pin_oe == '0) || (pin_oe == '1));

  // R2: straps frozen once drivers are on
  p_strap_hold_r2: assert property (@(posedge clk) disable iff (!pwr_good)
    ((pin_oe != '0) && $past(pin_oe != '0)) |-> $stable(strap_q));

  // R3: default straps before capture
  p_default_r3: assert property (@(posedge clk) disable iff (!pwr_good)
    (pin_oe == '0) |-> (strap_q == STRAP_DFLT));

  // R6: code register follows the select one edge later
  p_code_mux_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && $past(rst_n) && $past(rst_n, 2)) |=>
      (freq_code == ($past(sw_sel) ? $past(sw_code) : $past(strap_q[FS_W-1:0]))));

  // R7: shared pin idle before capture
  p_shared_idle_r7: assert property (@(posedge clk) disable iff (!pwr_good)
    (pin_oe == '0) |-> (!shr_oe && !stop_req));

  // R8: stop input ignored in clock mode
  p_stop_ignored_r8: assert property (@(posedge clk) disable iff (!pwr_good)
    (strap_q[IDX_MODE] && (pin_oe != '0)) |-> (shr_oe && !stop_req));
endmodule

bind strap_ctrl strap_ctrl_chk #(.WIN_CYC(WIN_CYC)) u_chk (
  .clk(clk), .pwr_good(pwr_good), .rst_n(rst_n), .sw_sel(sw_sel),
  .sw_code(sw_code), .pin_oe(pin_oe), .strap_q(strap_q),
  .freq_code(freq_code), .shr_oe(shr_oe), .stop_req(stop_req)
);

// File: tb/strap_ctrl_tb.sv
module strap_ctrl_tb;
  localparam int WIN = 16;

  logic       clk = 1'b0;
  logic       pwr_good = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] pin_in = 5'b00000;
  logic       sw_sel = 1'b0;
  logic [3:0] sw_code = 4'b0000;
  logic       shr_stop_n = 1'b1;
  logic [4:0] pin_oe, strap_q;
  logic [3:0] freq_code;
  logic       shr_oe, stop_req;

  int n_vec = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  strap_ctrl #(.WIN_CYC(WIN)) u_dut (
    .clk(clk), .pwr_good(pwr_good), .rst_n(rst_n), .pin_in(pin_in),
    .sw_sel(sw_sel), .sw_code(sw_code), .shr_stop_n(shr_stop_n),
    .pin_oe(pin_oe), .strap_q(strap_q), .freq_code(freq_code),
    .shr_oe(shr_oe), .stop_req(stop_req)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset_state;
    pwr_good = 1'b0; rst_n = 1'b0;
    edges(3);
    chk("R1 oe off in reset", 32'(pin_oe), 32'h0);
    chk("R3 strap default", 32'(strap_q), 32'h17);
    chk("R7 shared idle oe", 32'(shr_oe), 32'h0);
    shr_stop_n = 1'b0; #1;
    chk("R7 shared idle stop", 32'(stop_req), 32'h0);
    shr_stop_n = 1'b1;
    rst_n = 1'b1;
    edges(3);
    chk("R6 code reset value", 32'(freq_code), 32'h7);
  endtask

  // pwr_good rises at a falling edge; pins: a early, b at capture, c after
  task automatic t_window(input logic [4:0] a, input logic [4:0] b, input logic [4:0] c);
    pin_in = a;
    pwr_good = 1'b1;
    edges(WIN - 1);
    chk("R1 oe off mid window", 32'(pin_oe), 32'h0);
    pin_in = b;
    edges(1);
    pin_in = c;
    edges(1);
    chk("R1 oe off just before release", 32'(pin_oe), 32'h0);
    chk("R3 default just before release", 32'(strap_q), 32'h17);
    edges(1);
    chk("R1 oe on at release", 32'(pin_oe), 32'h1f);
    chk("R2 strap latched", 32'(strap_q), 32'(b));
    pin_in = ~b;
    edges(4);
    chk("R2 late pin change ignored", 32'(strap_q), 32'(b));
  endtask

  task automatic t_code_mux(input logic [3:0] strap_fs);
    sw_sel = 1'b0;
    edges(1);
    chk("R6 strap code", 32'(freq_code), 32'(strap_fs));
    sw_code = 4'b1100; sw_sel = 1'b1;
    edges(1);
    chk("R6 register code", 32'(freq_code), 32'hc);
    sw_code = 4'b0011;
    edges(1);
    chk("R6 register code follows", 32'(freq_code), 32'h3);
    sw_sel = 1'b0;
    edges(1);
    chk("R6 back to strap code", 32'(freq_code), 32'(strap_fs));
  endtask

  task automatic t_shared(input logic mode);
    shr_stop_n = 1'b0; #1;
    chk(mode ? "R8 stop ignored low" : "R7 stop asserted", 32'(stop_req), mode ? 32'h0 : 32'h1);
    chk(mode ? "R8 clock oe on" : "R7 clock oe off", 32'(shr_oe), mode ? 32'h1 : 32'h0);
    shr_stop_n = 1'b1; #1;
    chk(mode ? "R8 stop ignored high" : "R7 stop released", 32'(stop_req), 32'h0);
    edges(1);
  endtask

  task automatic t_soft_reset(input logic [4:0] held);
    rst_n = 1'b0;
    edges(4);
    chk("R4 strap kept", 32'(strap_q), 32'(held));
    chk("R4 oe kept", 32'(pin_oe), 32'h1f);
    chk("R6 code in reset", 32'(freq_code), 32'h7);
    rst_n = 1'b1;
    edges(3);
    chk("R4 strap kept after release", 32'(strap_q), 32'(held));
    chk("R6 code after release", 32'(freq_code), 32'(held[3:0]));
  endtask

  task automatic t_power_cycle;
    #2 pwr_good = 1'b0;
    #1;
    chk("R5 oe cleared at once", 32'(pin_oe), 32'h0);
    chk("R5 strap cleared at once", 32'(strap_q), 32'h17);
    edges(3);
  endtask

  initial begin
    t_reset_state();
    t_window(5'b00000, 5'b11010, 5'b00101);
    t_code_mux(4'b1010);
    t_shared(1'b1);
    t_soft_reset(5'b11010);
    t_power_cycle();
    t_window(5'b11111, 5'b01001, 5'b10110);
    t_code_mux(4'b1001);
    t_shared(1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule